// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a compact 32-bit processor that runs six instructions: wrapping add and subtract between registers, OR with an immediate, word load, word store, and branch-if-equal. Each instruction is fetched, decoded, executed and retired in one clock cycle. The program counter, the 32-entry register file and the data memory are all updated on the same rising edge. Register-file and memory reads are combinational.

The core holds a 256-word instruction store and a 256-word data store. The instruction store is filled through a simple write port, normally while reset is held. Execution is observed through debug outputs that show the current program counter and the register-file write performed by the current instruction. The reset input is active-low and asynchronous on assertion. Its release passes through a two-stage synchronizer, so the first instruction retires on the third rising edge after `rst_n` goes high.

Top module: `sc_core`

## Requirements
- R1: While reset is active, or before the synchronized release, `dbg_pc` is 0 and no register or memory write occurs; execution starts at address 0.
- R2: An instruction with op[31:26]=0x00 and funct[5:0]=0x21 writes R[rs]+R[rt] to R[rd]; funct 0x23 writes R[rs]-R[rt], modulo 2^32. The fields are rs[25:21], rt[20:16] and rd[15:11].
- R3: Op 0x0D writes R[rs] OR {16'h0, imm[15:0]} to R[rt]; the immediate is zero-extended.
- R4: Op 0x23 loads the data word at R[rs] plus the sign-extended imm[15:0] into R[rt].
- R5: Op 0x2B stores R[rt] to the data word at R[rs] plus the sign-extended immediate, and writes no register.
- R6: Op 0x04 writes nothing. If R[rs]==R[rt], the next PC is PC+4+(sign-extended imm shifted left by 2); otherwise it is PC+4.
- R7: Every instruction other than a taken branch moves the PC to PC+4.
- R8: Register 0 always reads as zero; a write aimed at it is shown on the debug outputs but has no effect.
- R9: An unrecognized opcode, or op 0x00 with a funct other than 0x21 or 0x23, writes neither a register nor memory, and the PC advances by 4.
- R10: Both memories index words with address bits [9:2]; bits [1:0] and bits above 9 are ignored.
- R11: `dbg_rf_we`, `dbg_rf_waddr` and `dbg_rf_wdata` show the register write of the instruction at `dbg_pc` during its cycle. A `prog_we` pulse stores `prog_data` at instruction word `prog_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 8 | Instruction store word index |
| prog_data | input | 32 | Instruction word to store |
| dbg_pc | output | 32 | Address of the instruction now executing |
| dbg_rf_we | output | 1 | Register write of this instruction is enabled |
| dbg_rf_waddr | output | 5 | Destination register of this instruction |
| dbg_rf_wdata | output | 32 | Value written to the destination register |

## Verification
The assertions check, on every cycle:
- the PC step of four after every non-branch instruction, and the branch target when a branch is taken;
- the zero read of register 0;
- that unrecognized encodings cause no writes;
- that a register write and a memory write never happen in the same cycle.

Arithmetic results, immediate extension, store-then-load round trips, address aliasing through the ignored address bits, and the fact that register 0 stays zero after a write can only be shown by the bench's program. That program is traced instruction by instruction against hand-derived values.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);
  localparam int MAW  = 8;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    dst_rd;
    logic    src_imm;
    logic    ext_sign;
    logic    wb_mem;
    logic    rf_we;
    logic    mem_we;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{dst_rd: 1'b0, src_imm: 1'b0, ext_sign: 1'b0, wb_mem: 1'b0,
             rf_we: 1'b0, mem_we: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    unique case (op)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        if (funct == FN_ADDU) begin
          ctrl.rf_we  = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.rf_we  = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OP_ORI: begin
        ctrl.src_imm = 1'b1;
        ctrl.rf_we   = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.rf_we    = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.ext_sign = 1'b1;
        ctrl.branch   = 1'b1;
        ctrl.alu_op   = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int W  = 32,
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[addr] <= wdata;
  end

  assign rdata = words[addr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_AW = MAW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [MEM_AW-1:0] prog_addr,
  input  logic [XLEN-1:0]   prog_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_rf_we,
  output logic [RAW-1:0]    dbg_rf_waddr,
  output logic [XLEN-1:0]   dbg_rf_wdata
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign run = rsync_q[1];

  logic [XLEN-1:0] pc_q, pc_d, pc_seq, br_off;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, dmem_q, wb_val;
  logic [RAW-1:0]  rs_a, rt_a, rd_a, wr_a;
  logic [15:0]     imm16;
  logic            alu_zero, rf_we_g, mem_we_g;
  ctrl_t           ctrl;

  sc_mem #(.W(XLEN), .AW(MEM_AW)) u_imem (
    .clk(clk), .we(prog_we), .addr(prog_we ? prog_addr : pc_q[MEM_AW+1:2]),
    .wdata(prog_data), .rdata(instr)
  );

  assign rs_a  = instr[25:21];
  assign rt_a  = instr[20:16];
  assign rd_a  = instr[15:11];
  assign imm16 = instr[15:0];

  sc_ctrl u_ctrl (.op(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl));

  assign imm_ext = ctrl.ext_sign ? {{(XLEN-16){imm16[15]}}, imm16}
                                 : {{(XLEN-16){1'b0}}, imm16};
  assign wr_a    = ctrl.dst_rd ? rd_a : rt_a;
  assign rf_we_g  = ctrl.rf_we  & run;
  assign mem_we_g = ctrl.mem_we & run;

  sc_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .we(rf_we_g), .waddr(wr_a), .wdata(wb_val),
    .raddr_a(rs_a), .rdata_a(rs_val), .raddr_b(rt_a), .rdata_b(rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op(ctrl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  sc_mem #(.W(XLEN), .AW(MEM_AW)) u_dmem (
    .clk(clk), .we(mem_we_g), .addr(alu_y[MEM_AW+1:2]),
    .wdata(rt_val), .rdata(dmem_q)
  );

  assign wb_val = ctrl.wb_mem ? dmem_q : alu_y;

  // next-address logic
  assign pc_seq = pc_q + STEP;
  assign br_off = {imm_ext[XLEN-3:0], 2'b00};
  always_comb begin
    pc_d = pc_seq;
    if (ctrl.branch && alu_zero) pc_d = pc_seq + br_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (!run) pc_q <= '0;
    else          pc_q <= pc_d;
  end

  assign dbg_pc       = pc_q;
  assign dbg_rf_we    = rf_we_g;
  assign dbg_rf_waddr = wr_a;
  assign dbg_rf_wdata = wb_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic            clk,
  input logic            run,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic [RAW-1:0]  rs_a,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            rf_we,
  input logic            mem_we
);
  logic [5:0] op;
  logic [5:0] fn;
  logic       known;
  logic       beq_taken;
  assign op = instr[31:26];
  assign fn = instr[5:0];
  assign known = (op == 6'h0D) || (op == 6'h23) || (op == 6'h2B) || (op == 6'h04) ||
                 ((op == 6'h00) && ((fn == 6'h21) || (fn == 6'h23)));
  assign beq_taken = (op == 6'h04) && (rs_val == rt_val);

  // R7
  p_seq_step_r7: assert property (@(posedge clk) disable iff (!run)
    !beq_taken |=> pc == $past(pc) + 32'd4);

  // R6
  p_branch_target_r6: assert property (@(posedge clk) disable iff (!run)
    beq_taken |=> pc == $past(pc) + 32'd4 +
      {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  // R8
  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!run)
    (rs_a == '0) |-> (rs_val == '0));

  // R9
  p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!run)
    !known |-> (!rf_we && !mem_we));

  // R5
  p_write_exclusive_r5: assert property (@(posedge clk) disable iff (!run)
    !(rf_we && mem_we));

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk)
    !run |-> (pc == '0 && !rf_we && !mem_we));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .run(run), .pc(pc_q), .instr(instr), .rs_a(rs_a),
  .rs_val(rs_val), .rt_val(rt_val), .rf_we(rf_we_g), .mem_we(mem_we_g)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we;
  logic [7:0]  prog_addr;
  logic [31:0] prog_data;
  logic [31:0] dbg_pc;
  logic        dbg_rf_we;
  logic [4:0]  dbg_rf_waddr;
  logic [31:0] dbg_rf_wdata;

  always #4 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .dbg_pc(dbg_pc), .dbg_rf_we(dbg_rf_we),
    .dbg_rf_waddr(dbg_rf_waddr), .dbg_rf_wdata(dbg_rf_wdata)
  );

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  logic  mon_en = 1'b0;
  logic  done = 1'b0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic load(int idx, logic [31:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 8'(idx); prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic expect_step(logic [31:0] pc, logic we, int wa, logic [31:0] wd, string tag);
    item_t it;
    it.pc = pc; it.we = we; it.wa = 5'(wa); it.wd = wd; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_en && !done) begin
      if (sb.size() == 0) begin
        done <= 1'b1;
      end else begin
        item_t it;
        it = sb.pop_front();
        n_cmp++;
        if (dbg_pc !== it.pc) begin
          n_bad++;
          $display("FAIL %s pc: actual %h expected %h", it.tag, dbg_pc, it.pc);
        end
        n_cmp++;
        if (dbg_rf_we !== it.we ||
            (it.we && (dbg_rf_waddr !== it.wa || dbg_rf_wdata !== it.wd))) begin
          n_bad++;
          $display("FAIL %s write: actual we=%b r%0d=%h expected we=%b r%0d=%h",
                   it.tag, dbg_rf_we, dbg_rf_waddr, dbg_rf_wdata, it.we, it.wa, it.wd);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    // R11 program load
    load(0,  enc_i(6'h0D, 0, 1, 16'h1234));        // ori  r1,r0,0x1234
    load(1,  enc_i(6'h0D, 0, 2, 16'hFFFF));        // ori  r2,r0,0xFFFF
    load(2,  enc_r(1, 2, 3, 6'h21));               // addu r3,r1,r2
    load(3,  enc_r(1, 2, 4, 6'h23));               // subu r4,r1,r2
    load(4,  enc_i(6'h2B, 0, 3, 16'h0008));        // sw   r3,8(r0)
    load(5,  enc_i(6'h2B, 1, 4, 16'hFFFC));        // sw   r4,-4(r1)
    load(6,  enc_i(6'h23, 0, 5, 16'h0008));        // lw   r5,8(r0)
    load(7,  enc_i(6'h23, 0, 6, 16'h0231));        // lw   r6,0x231(r0)
    load(8,  enc_r(1, 1, 0, 6'h21));               // addu r0,r1,r1
    load(9,  enc_r(0, 1, 7, 6'h21));               // addu r7,r0,r1
    load(10, enc_i(6'h3F, 1, 9, 16'h0001));        // unknown op
    load(11, enc_r(1, 2, 9, 6'h20));               // unknown funct
    load(12, enc_i(6'h04, 1, 2, 16'h0005));        // beq r1,r2 (not taken)
    load(13, enc_i(6'h04, 5, 3, 16'h0002));        // beq r5,r3 (taken)
    load(14, enc_i(6'h0D, 0, 9, 16'h0BAD));        // skipped
    load(15, enc_i(6'h0D, 0, 9, 16'h0BAD));        // skipped
    load(16, enc_i(6'h0D, 0, 8, 16'h5555));        // ori r8,r0,0x5555
    load(17, enc_i(6'h04, 0, 0, 16'hFFFF));        // beq r0,r0,-1 (self loop)

    @(negedge clk);
    n_cmp++;
    if (dbg_pc !== 32'd0 || dbg_rf_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual pc=%h we=%b expected pc=0 we=0", dbg_pc, dbg_rf_we);
    end

    // driver: expected trace
    expect_step(32'd0,  1, 1, 32'h0000_1234, "R3 ori");
    expect_step(32'd4,  1, 2, 32'h0000_FFFF, "R3 zero-extend");
    expect_step(32'd8,  1, 3, 32'h0001_1233, "R2 addu");
    expect_step(32'd12, 1, 4, 32'hFFFF_1235, "R2 subu wrap");
    expect_step(32'd16, 0, 0, 32'h0,         "R5 sw no reg write");
    expect_step(32'd20, 0, 0, 32'h0,         "R5 sw negative offset");
    expect_step(32'd24, 1, 5, 32'h0001_1233, "R4 lw round trip");
    expect_step(32'd28, 1, 6, 32'hFFFF_1235, "R10 lw aliased index");
    expect_step(32'd32, 1, 0, 32'h0000_2468, "R8 write to r0 shown");
    expect_step(32'd36, 1, 7, 32'h0000_1234, "R8 r0 still zero");
    expect_step(32'd40, 0, 0, 32'h0,         "R9 unknown op");
    expect_step(32'd44, 0, 0, 32'h0,         "R9 unknown funct");
    expect_step(32'd48, 0, 0, 32'h0,         "R6 beq not taken");
    expect_step(32'd52, 0, 0, 32'h0,         "R6 beq taken");
    expect_step(32'd64, 1, 8, 32'h0000_5555, "R6 branch target");
    expect_step(32'd68, 0, 0, 32'h0,         "R7 self loop");
    expect_step(32'd68, 0, 0, 32'h0,         "R6 negative offset");
    expect_step(32'd68, 0, 0, 32'h0,         "R11 debug trace");

    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    n_cmp++;
    if (dbg_pc !== 32'd0 || dbg_rf_we !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 sync release: actual pc=%h we=%b expected pc=0 we=0", dbg_pc, dbg_rf_we);
    end
    @(posedge clk);
    mon_en = 1'b1;
    wait (done);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule